// File: doc/BRIEF.md
# Read-Modify-Write Fused-Operation Unit

This block runs the fused read-modify-write instructions of an 8-bit accumulator CPU. The CPU presents a decoded operation, the effective address of the operand byte, the current accumulator and the carry. The block reads the byte and changes it with a shift, rotate, increment or decrement. It writes the byte back and then uses the changed byte, together with the carry from the first step, in a second accumulator operation. The second step never sees the original memory byte.

Memory is reached through a single-port request/acknowledge handshake. A transfer completes in the cycle where both `mem_req_o` and `mem_ack_i` are high. Every operation makes three transfers to the same address: one read, then a write of the unchanged byte, then a write of the changed byte. A one-cycle `done_o` pulse follows the last write. The accumulator and flag outputs change only on that pulse and hold until the next one. Address generation, opcode fetch and interrupts belong elsewhere. Arithmetic is binary only, and no decimal mode exists.

Top module: `rmw_fused_unit`

## Requirements
- R1: While `rst_n` is low, `mem_req_o`, `busy_o` and `done_o` are low, and `acc_o`, `carry_o`, `neg_o`, `zero_o` and `ovf_o` are 0.
- R2: A start makes exactly one read of `addr_i`, then a write of the original byte, then a write of the final write-back byte, all to that address. Request signals hold steady until acknowledged. `done_o` is high for exactly one cycle, the cycle after the last acknowledge. With one-cycle acknowledges, `done_o` is seen 7 clock edges after the start edge.
- R3: Op code 0 (shift-left-or): byte shifted left with 0 into bit 0. Carry takes the old bit 7. The accumulator becomes the shifted byte OR accumulator, and that OR value is also the final write-back.
- R4: Op code 1 (rotate-left-and): byte rotated left with the input carry into bit 0. Carry takes the old bit 7. The rotated byte is written back. The accumulator becomes rotated byte AND accumulator.
- R5: Op code 2 (shift-right-xor): byte shifted right with 0 into bit 7. Carry takes the old bit 0. The shifted byte is written back. The accumulator becomes accumulator XOR shifted byte.
- R6: Op code 3 (rotate-right-add): byte rotated right with the input carry into bit 7, and written back. The accumulator becomes accumulator + rotated byte + old bit 0 (binary). Carry is the carry out of the sum. `ovf_o` is the signed overflow of that sum.
- R7: Op code 4 (decrement-compare): byte minus 1 (modulo 256) is written back. The accumulator is unchanged. Carry is 1 when accumulator >= decremented byte (unsigned). `neg_o` and `zero_o` follow accumulator minus decremented byte.
- R8: Op code 5 (increment-subtract): byte plus 1 (modulo 256) is written back. The accumulator becomes accumulator - incremented byte - (1 - input carry) (binary). Carry is 1 when no borrow occurred. `ovf_o` is the signed overflow of that subtraction.
- R9: A start with op code 6 or 7 is ignored. No memory request is made, `busy_o` stays low and all result outputs keep their values.
- R10: A start while `busy_o` is high is ignored, and the running operation completes with its own operands.
- R11: For op codes 0, 1, 2 and 4, `ovf_o` is 0. For every op, `neg_o` is bit 7 of the result (the accumulator, or the compare difference for op 4), and `zero_o` is 1 when that result is 0.
- R12: `acc_o`, `carry_o`, `neg_o`, `zero_o` and `ovf_o` change only in the cycle where `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled when idle |
| op_i | input | 3 | Fused operation code (0..5 valid) |
| addr_i | input | ADDR_W | Effective operand address |
| acc_i | input | DATA_W | Accumulator at start |
| carry_i | input | 1 | Carry at start |
| busy_o | output | 1 | Operation in progress |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | DATA_W | Read data, valid with acknowledge of a read |
| done_o | output | 1 | One-cycle completion pulse |
| acc_o | output | DATA_W | New accumulator |
| carry_o | output | 1 | New carry |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
The bench builds the unit with `ADDR_W` = 10 and the default `DATA_W` = 8. A 1024-byte memory model can then back every address, and all byte arithmetic corners are reachable. These corners are bit 7 and bit 0 leaving through carry, the decrement wrapping from 0 to 255, the increment wrapping from 255 to 0, and signed overflow in both the add and subtract paths. The memory model logs each transfer, so the read/write/write order and the values written are checked as well as the flags.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  typedef enum logic [2:0] {
    OP_SHL_OR  = 3'd0,
    OP_ROL_AND = 3'd1,
    OP_SHR_XOR = 3'd2,
    OP_ROR_ADD = 3'd3,
    OP_DEC_CMP = 3'd4,
    OP_INC_SUB = 3'd5
  } rmw_op_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_READ    = 3'd1,
    ST_WR_ORIG = 3'd2,
    ST_WR_MOD  = 3'd3,
    ST_FIN     = 3'd4
  } rmw_state_e;

  function automatic logic op_valid(input logic [2:0] code);
    return code <= 3'd5;
  endfunction

endpackage

// File: rtl/rmw_modify.sv
module rmw_modify
  import rmw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  rmw_op_e           op,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              c_in,
  output logic [DATA_W-1:0] byte_mod,
  output logic              c_mid
);
  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    byte_mod = byte_in;
    c_mid    = c_in;
    unique case (op)
      OP_SHL_OR: begin
        byte_mod = {byte_in[MSB-1:0], 1'b0};
        c_mid    = byte_in[MSB];
      end
      OP_ROL_AND: begin
        byte_mod = {byte_in[MSB-1:0], c_in};
        c_mid    = byte_in[MSB];
      end
      OP_SHR_XOR: begin
        byte_mod = {1'b0, byte_in[MSB:1]};
        c_mid    = byte_in[0];
      end
      OP_ROR_ADD: begin
        byte_mod = {c_in, byte_in[MSB:1]};
        c_mid    = byte_in[0];
      end
      OP_DEC_CMP: byte_mod = byte_in - ONE;
      OP_INC_SUB: byte_mod = byte_in + ONE;
      default: ;
    endcase
  end
endmodule

// File: rtl/rmw_accum.sv
module rmw_accum
  import rmw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  rmw_op_e           op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] byte_mod,
  input  logic              c_mid,
  output logic [DATA_W-1:0] acc_new,
  output logic [DATA_W-1:0] wb_byte,
  output logic              c_new,
  output logic              n_new,
  output logic              z_new,
  output logic              v_new
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0]   sum_add;
  logic [DATA_W:0]   sum_sub;
  logic [DATA_W-1:0] flag_src;

  // Add path and subtract path (A + ~M + carry_in)
  assign sum_add = {1'b0, acc} + {1'b0, byte_mod} + {{DATA_W{1'b0}}, c_mid};
  assign sum_sub = {1'b0, acc} + {1'b0, ~byte_mod} +
                   {{DATA_W{1'b0}}, (op == OP_DEC_CMP) ? 1'b1 : c_mid};

  always_comb begin
    acc_new  = acc;
    wb_byte  = byte_mod;
    c_new    = c_mid;
    v_new    = 1'b0;
    flag_src = acc;
    unique case (op)
      OP_SHL_OR: begin
        acc_new = acc | byte_mod;
        wb_byte = acc | byte_mod;
      end
      OP_ROL_AND: acc_new = acc & byte_mod;
      OP_SHR_XOR: acc_new = acc ^ byte_mod;
      OP_ROR_ADD: begin
        acc_new = sum_add[MSB:0];
        c_new   = sum_add[DATA_W];
        v_new   = (acc[MSB] == byte_mod[MSB]) && (sum_add[MSB] != acc[MSB]);
      end
      OP_DEC_CMP: begin
        c_new = sum_sub[DATA_W];
      end
      OP_INC_SUB: begin
        acc_new = sum_sub[MSB:0];
        c_new   = sum_sub[DATA_W];
        v_new   = (acc[MSB] != byte_mod[MSB]) && (sum_sub[MSB] != acc[MSB]);
      end
      default: ;
    endcase
    flag_src = (op == OP_DEC_CMP) ? sum_sub[MSB:0] : acc_new;
    n_new    = flag_src[MSB];
    z_new    = (flag_src == '0);
  end
endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
  import rmw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_ok,
  input  logic       ack,
  output rmw_state_e state,
  output logic       load_ops,
  output logic       load_orig,
  output logic       load_res
);
  rmw_state_e state_nxt;

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE:    if (start_ok) state_nxt = ST_READ;
      ST_READ:    if (ack) state_nxt = ST_WR_ORIG;
      ST_WR_ORIG: if (ack) state_nxt = ST_WR_MOD;
      ST_WR_MOD:  if (ack) state_nxt = ST_FIN;
      ST_FIN:     state_nxt = ST_IDLE;
      default:    state_nxt = ST_IDLE;
    endcase
  end

  assign load_ops  = (state == ST_IDLE) && start_ok;
  assign load_orig = (state == ST_READ) && ack;
  assign load_res  = (state == ST_WR_MOD) && ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end
endmodule

// File: rtl/rmw_fused_unit.sv
module rmw_fused_unit
  import rmw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              carry_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              carry_o,
  output logic              neg_o,
  output logic              zero_o,
  output logic              ovf_o
);
  rmw_state_e        state;
  logic              start_ok, xfer_ack;
  logic              load_ops, load_orig, load_res;
  rmw_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] acc_q, orig_q;
  logic              c_q;
  logic [DATA_W-1:0] byte_mod, acc_new, wb_byte;
  logic              c_mid, c_new, n_new, z_new, v_new;

  assign start_ok = start_i && op_valid(op_i);
  assign xfer_ack = mem_req_o && mem_ack_i;

  rmw_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ok (start_ok),
    .ack      (xfer_ack),
    .state    (state),
    .load_ops (load_ops),
    .load_orig(load_orig),
    .load_res (load_res)
  );

  // Operand capture with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_SHL_OR;
      addr_q <= '0;
      acc_q  <= '0;
      c_q    <= 1'b0;
    end else if (load_ops) begin
      op_q   <= rmw_op_e'(op_i);
      addr_q <= addr_i;
      acc_q  <= acc_i;
      c_q    <= carry_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         orig_q <= '0;
    else if (load_orig) orig_q <= mem_rdata_i;
  end

  rmw_modify #(.DATA_W(DATA_W)) u_modify (
    .op      (op_q),
    .byte_in (orig_q),
    .c_in    (c_q),
    .byte_mod(byte_mod),
    .c_mid   (c_mid)
  );

  rmw_accum #(.DATA_W(DATA_W)) u_accum (
    .op      (op_q),
    .acc     (acc_q),
    .byte_mod(byte_mod),
    .c_mid   ((op_q == OP_INC_SUB) ? c_q : c_mid),
    .acc_new (acc_new),
    .wb_byte (wb_byte),
    .c_new   (c_new),
    .n_new   (n_new),
    .z_new   (z_new),
    .v_new   (v_new)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_o   <= '0;
      carry_o <= 1'b0;
      neg_o   <= 1'b0;
      zero_o  <= 1'b0;
      ovf_o   <= 1'b0;
    end else if (load_res) begin
      acc_o   <= acc_new;
      carry_o <= c_new;
      neg_o   <= n_new;
      zero_o  <= z_new;
      ovf_o   <= v_new;
    end
  end

  assign busy_o      = (state != ST_IDLE);
  assign done_o      = (state == ST_FIN);
  assign mem_req_o   = (state == ST_READ) || (state == ST_WR_ORIG) || (state == ST_WR_MOD);
  assign mem_we_o    = (state == ST_WR_ORIG) || (state == ST_WR_MOD);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = (state == ST_WR_MOD) ? wb_byte : orig_q;

endmodule

// File: rtl/rmw_fused_unit_chk.sv
module rmw_fused_unit_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [2:0]        op_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic [DATA_W-1:0] acc_o,
  input logic              carry_o
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !mem_req_o && !busy_o && !done_o);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_we_o) &&
                                 $stable(mem_addr_o) && $stable(mem_wdata_o));

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R2
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_req_o);

  // R9
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start_i && (op_i > 3'd5) |=> !busy_o);

  // R12
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(acc_o) && $stable(carry_o)) |-> done_o);
endmodule

bind rmw_fused_unit rmw_fused_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .busy_o(busy_o),
  .done_o(done_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_ack_i(mem_ack_i), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
  .acc_o(acc_o), .carry_o(carry_o)
);

// File: tb/test_rmw_fused_unit.sv
`timescale 1ns/1ps
module test_rmw_fused_unit;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0] acc_i = '0;
  logic carry_i = 1'b0;
  logic busy_o, mem_req_o, mem_we_o, done_o, carry_o, neg_o, zero_o, ovf_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0] mem_wdata_o, acc_o, mem_rdata_i;
  logic mem_ack_i;

  always #10 clk = ~clk;

  rmw_fused_unit #(.ADDR_W(AW), .DATA_W(8)) i_rmw_fused_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .addr_i(addr_i),
    .acc_i(acc_i), .carry_i(carry_i), .busy_o(busy_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i), .done_o(done_o),
    .acc_o(acc_o), .carry_o(carry_o), .neg_o(neg_o), .zero_o(zero_o), .ovf_o(ovf_o)
  );

  // Memory model with transfer log
  logic [7:0] mem [0:(1<<AW)-1];
  logic       pre_en = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic [7:0] pre_data = '0;
  logic       log_clr = 1'b0;
  int         rd_cnt, wr_cnt;
  logic [7:0] wr_val [0:3];
  logic [AW-1:0] wr_adr [0:3];
  logic [AW-1:0] rd_adr;

  always @(posedge clk) begin
    if (pre_en) mem[pre_addr] <= pre_data;
    if (log_clr) begin
      rd_cnt <= 0;
      wr_cnt <= 0;
    end
    if (!rst_n) begin
      mem_ack_i <= 1'b0;
    end else if (mem_req_o && !mem_ack_i) begin
      mem_ack_i <= 1'b1;
      if (mem_we_o) begin
        mem[mem_addr_o] <= mem_wdata_o;
        if (wr_cnt < 4) begin
          wr_val[wr_cnt] <= mem_wdata_o;
          wr_adr[wr_cnt] <= mem_addr_o;
        end
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata_i <= mem[mem_addr_o];
        rd_adr <= mem_addr_o;
        rd_cnt <= rd_cnt + 1;
      end
    end else begin
      mem_ack_i <= 1'b0;
    end
  end

  int n_checks = 0;
  int n_fail = 0;
  bit timed_out = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Expected result from the requirement text
  typedef struct { logic [7:0] acc; logic c, n, z, v; logic [7:0] wb; } exp_t;

  function automatic exp_t model(input int op, input logic [7:0] m,
                                 input logic [7:0] a, input logic c);
    exp_t e;
    int s;
    logic [7:0] t;
    e.v = 0; e.acc = a;
    case (op)
      0: begin t = (m << 1) & 8'hFF; e.c = m[7]; e.acc = t | a; e.wb = t | a; end
      1: begin t = ((m << 1) & 8'hFF) | c; e.c = m[7]; e.acc = t & a; e.wb = t; end
      2: begin t = m >> 1; e.c = m[0]; e.acc = a ^ t; e.wb = t; end
      3: begin
        t = (m >> 1) | (c ? 8'h80 : 8'h00); e.wb = t;
        s = int'(a) + int'(t) + int'(m[0]);
        e.acc = s[7:0]; e.c = (s > 255);
        e.v = ($signed(a) + $signed(t) + int'(m[0]) > 127) ||
              ($signed(a) + $signed(t) + int'(m[0]) < -128);
      end
      4: begin
        t = m - 8'd1; e.wb = t; e.c = (a >= t);
        e.n = ((a - t) & 8'hFF) >= 8'h80; e.z = (a == t);
        return e;
      end
      default: begin
        t = m + 8'd1; e.wb = t;
        s = int'(a) - int'(t) - (c ? 0 : 1);
        e.acc = s[7:0]; e.c = (s >= 0);
        e.v = ($signed(a) - $signed(t) - (c ? 0 : 1) > 127) ||
              ($signed(a) - $signed(t) - (c ? 0 : 1) < -128);
      end
    endcase
    e.n = e.acc[7];
    e.z = (e.acc == 8'h00);
    return e;
  endfunction

  task automatic preload(input logic [AW-1:0] ad, input logic [7:0] d);
    pre_en = 1; pre_addr = ad; pre_data = d; log_clr = 1;
    @(negedge clk);
    pre_en = 0; log_clr = 0;
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done_o && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    if (!done_o) begin
      timed_out = 1;
      chk("R2 done timeout", 0, 1);
    end
  endtask

  task automatic run_op(input string tag, input int op, input logic [AW-1:0] ad,
                        input logic [7:0] m, input logic [7:0] a, input logic c,
                        input bit poke_busy);
    exp_t e;
    int lat;
    e = model(op, m, a, c);
    preload(ad, m);
    start_i = 1; op_i = 3'(op); addr_i = ad; acc_i = a; carry_i = c;
    @(negedge clk);
    start_i = 0;
    if (poke_busy) begin
      @(negedge clk);
      start_i = 1; op_i = 3'd0; addr_i = ad + 1; acc_i = ~a; carry_i = ~c;
      @(negedge clk);
      start_i = 0;
      wait_done(lat);
      lat = lat + 2;
    end else begin
      wait_done(lat);
    end
    chk({tag, " acc"}, acc_o, e.acc);
    chk({tag, " carry"}, carry_o, e.c);
    chk({tag, " neg (R11)"}, neg_o, e.n);
    chk({tag, " zero (R11)"}, zero_o, e.z);
    chk({tag, " ovf (R11)"}, ovf_o, e.v);
    chk({tag, " R2 latency"}, lat, 7);
    chk({tag, " R2 reads"}, rd_cnt, 1);
    chk({tag, " R2 writes"}, wr_cnt, 2);
    chk({tag, " R2 read addr"}, rd_adr, ad);
    chk({tag, " R2 first write orig"}, wr_val[0], m);
    chk({tag, " R2 second write"}, wr_val[1], e.wb);
    chk({tag, " R2 write addr"}, wr_adr[1], ad);
    @(negedge clk);
    chk({tag, " R2 done single"}, done_o, 0);
  endtask

  task automatic t_reset();
    chk("R1 req", mem_req_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 acc", acc_o, 0);
    chk("R1 flags", {carry_o, neg_o, zero_o, ovf_o}, 0);
  endtask

  task automatic t_bad_op(input int op);
    logic [7:0] acc0;
    logic [3:0] fl0;
    bit any_req = 0, any_busy = 0;
    acc0 = acc_o; fl0 = {carry_o, neg_o, zero_o, ovf_o};
    preload(10'h55, 8'h3C);
    start_i = 1; op_i = 3'(op); acc_i = ~acc0; carry_i = ~carry_o; addr_i = 10'h55;
    @(negedge clk);
    start_i = 0;
    for (int i = 0; i < 10; i++) begin
      any_req |= mem_req_o;
      any_busy |= busy_o;
      @(negedge clk);
    end
    chk("R9 no request", any_req, 0);
    chk("R9 not busy", any_busy, 0);
    chk("R9 acc held", acc_o, acc0);
    chk("R9 flags held", {carry_o, neg_o, zero_o, ovf_o}, fl0);
    chk("R9 no transfers", rd_cnt + wr_cnt, 0);
  endtask

  initial begin
    fork
      begin
        repeat (200) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        run_op("R3 shl_or", 0, 10'h010, 8'h81, 8'h10, 1'b0, 0);
        run_op("R3 shl_or", 0, 10'h011, 8'h00, 8'h00, 1'b1, 0);
        run_op("R4 rol_and", 1, 10'h020, 8'h40, 8'hC0, 1'b1, 0);
        run_op("R4 rol_and", 1, 10'h021, 8'hFF, 8'h0F, 1'b0, 0);
        run_op("R5 shr_xor", 2, 10'h030, 8'h01, 8'h00, 1'b1, 0);
        run_op("R5 shr_xor", 2, 10'h031, 8'hAA, 8'hFF, 1'b0, 0);
        run_op("R6 ror_add", 3, 10'h040, 8'h01, 8'h7F, 1'b1, 0);
        run_op("R6 ror_add", 3, 10'h041, 8'h02, 8'h7F, 1'b0, 0);
        run_op("R6 ror_add", 3, 10'h042, 8'h03, 8'h80, 1'b1, 0);
        run_op("R7 dec_cmp", 4, 10'h050, 8'h00, 8'h05, 1'b1, 0);
        run_op("R7 dec_cmp", 4, 10'h051, 8'h06, 8'h05, 1'b0, 0);
        run_op("R7 dec_cmp", 4, 10'h052, 8'h10, 8'h80, 1'b0, 0);
        run_op("R8 inc_sub", 5, 10'h060, 8'hFF, 8'h00, 1'b1, 0);
        run_op("R8 inc_sub", 5, 10'h061, 8'h00, 8'h80, 1'b1, 0);
        run_op("R8 inc_sub", 5, 10'h062, 8'h00, 8'h80, 1'b0, 0);
        run_op("R8 inc_sub", 5, 10'h3FF, 8'h7E, 8'h10, 1'b1, 0);
        t_bad_op(6);
        t_bad_op(7);
        run_op("R10 busy start", 3, 10'h070, 8'h11, 8'h22, 1'b1, 1);
        run_op("R12 back2back", 1, 10'h071, 8'hF0, 8'h3C, 1'b0, 0);
      end
      begin
        repeat (100000) @(negedge clk);
        timed_out = 1;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule